// File: doc/BRIEF.md
# Keyed Down-Counting Watchdog Timer

The block is a watchdog timer that software controls through a small word-addressed register bus with 32-bit data. Software picks a period for the first interval after enable and a period for every later interval. Each period is a power of two: 2^(BASE_EXP+n) clock cycles, where n is a 4-bit select (0 to 15). Software then enables the counter. Once enabled, the counter cannot be stopped except by a reset of the block. Software keeps the system alive by writing a fixed key word to a restart register, which reloads the counter.

When the count runs out, the response depends on a mode bit. In the direct mode, the block issues a fixed-length system-reset request. In the two-stage mode, the first expiry only raises an interrupt and reloads the counter. A second expiry while that interrupt is still pending issues the reset request. The live count can be read back at any time, so software can work out the time left.

Top module: `wdog_timer`

## Requirements
- R1: After reset, control and range registers read 0, the count reads 0, and irq_o and sysrst_o are low.
- R2: Word address 0 is control (bit 0 enable, bit 1 mode; other bits read 0). Address 1 is range (bits [3:0] running select, bits [7:4] initial select; other bits read 0). Address 2 reads the live count. Address 3 is the restart register and reads 0.
- R3: Once the enable bit is 1, writing 0 to it leaves it at 1. Only rst_n clears it.
- R4: The write that turns enable from 0 to 1 loads the count with 2^(BASE_EXP+initial select), visible in the next cycle.
- R5: While enabled, the count drops by exactly 1 per cycle. While disabled, it stays at 0 and irq_o stays low.
- R6: Writing exactly 0x00000076 to address 3 while enabled reloads the count with 2^(BASE_EXP+running select) and clears irq_o. Any other value written there, or any write there while disabled, changes nothing.
- R7: Every select value n from 0 to 15 gives a reload of 2^(BASE_EXP+n).
- R8: With mode 0, the cycle after the count reaches 0 raises sysrst_o with irq_o low, and the count reloads from the running select.
- R9: With mode 1 and no interrupt pending, an expiry sets irq_o, reloads from the running select, and leaves sysrst_o low.
- R10: With mode 1 and irq_o already set, an expiry raises sysrst_o, and irq_o stays set.
- R11: Each reset request holds sysrst_o high for exactly PULSE_LEN (8) cycles.
- R12: Writes to address 2 have no effect on the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_we | input | 1 | Write when high, with bus_sel |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for bus_addr (combinational) |
| irq_o | output | 1 | Pending interrupt from a first expiry |
| sysrst_o | output | 1 | System-reset request pulse |

## Verification
The assertions check four things on every cycle:
- the enable bit never falls once set;
- the count steps down by one unless a valid key arrives, including when a wrong key is written;
- a valid key clears the interrupt;
- the interrupt and the reset request only start right after the count has been zero, and each reset pulse ends after exactly PULSE_LEN cycles.

Only the bench scenarios can show the exact loaded values for the initial and running selects, including the largest period. They also show the difference between the first and the second expiry in two-stage mode, and that the control, range and count registers read back correctly.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int unsigned IDX_CTRL  = 0;
  localparam int unsigned IDX_RANGE = 1;
  localparam int unsigned IDX_COUNT = 2;
  localparam int unsigned IDX_KICK  = 3;

  localparam int unsigned SEL_W = 4;
  localparam logic [31:0] KICK_KEY = 32'h0000_0076;

  typedef struct packed {
    logic mode;
    logic en;
  } ctrl_t;

  typedef struct packed {
    logic [SEL_W-1:0] sel_init;
    logic [SEL_W-1:0] sel_run;
  } range_t;
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int unsigned ADDR_W = 2,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [CNT_W-1:0]  cnt,
  output ctrl_t             ctrl_q,
  output range_t            range_q,
  output logic              start,
  output logic              kick,
  output logic [DATA_W-1:0] bus_rdata
);
  localparam int unsigned RANGE_W = $bits(range_t);

  logic   wr_any, wr_ctrl, wr_range, wr_kick;
  ctrl_t  ctrl_d;
  range_t range_d;

  assign wr_any   = bus_sel & bus_we;
  assign wr_ctrl  = wr_any & (bus_addr == ADDR_W'(IDX_CTRL));
  assign wr_range = wr_any & (bus_addr == ADDR_W'(IDX_RANGE));
  assign wr_kick  = wr_any & (bus_addr == ADDR_W'(IDX_KICK));

  assign start = wr_ctrl & bus_wdata[0] & ~ctrl_q.en;
  assign kick  = wr_kick & ctrl_q.en & (bus_wdata == DATA_W'(KICK_KEY));

  always_comb begin
    ctrl_d      = ctrl_q;
    ctrl_d.en   = ctrl_q.en | bus_wdata[0];
    ctrl_d.mode = bus_wdata[1];
    range_d     = range_t'(bus_wdata[RANGE_W-1:0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      range_q <= '0;
    end else begin
      if (wr_ctrl)  ctrl_q  <= ctrl_d;
      if (wr_range) range_q <= range_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      ADDR_W'(IDX_CTRL):  bus_rdata = DATA_W'(ctrl_q);
      ADDR_W'(IDX_RANGE): bus_rdata = DATA_W'(range_q);
      ADDR_W'(IDX_COUNT): bus_rdata = DATA_W'(cnt);
      default:            bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/wdog_count.sv
module wdog_count
  import wdog_pkg::*;
#(
  parameter int unsigned BASE_EXP = 16,
  parameter int unsigned CNT_W    = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             start,
  input  logic             kick,
  input  logic [SEL_W-1:0] sel_init,
  input  logic [SEL_W-1:0] sel_run,
  output logic [CNT_W-1:0] cnt_q,
  output logic             expire
);
  function automatic logic [CNT_W-1:0] period_of(input logic [SEL_W-1:0] s);
    period_of = CNT_W'(1) << (BASE_EXP + int'(s));
  endfunction

  logic [CNT_W-1:0] cnt_d;
  logic             cnt_ce;

  assign expire = en & ~kick & (cnt_q == '0);
  assign cnt_ce = start | en;

  always_comb begin
    if (start)
      cnt_d = period_of(sel_init);
    else if (kick || expire)
      cnt_d = period_of(sel_run);
    else
      cnt_d = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_ce) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/wdog_resp.sv
module wdog_resp #(
  parameter int unsigned PULSE_LEN = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic expire,
  input  logic mode,
  input  logic kick,
  output logic irq_q,
  output logic sysrst
);
  localparam int unsigned PW = $clog2(PULSE_LEN + 1);

  logic          fire;
  logic          irq_d;
  logic          irq_ce;
  logic [PW-1:0] pcnt_q, pcnt_d;
  logic          pcnt_ce;

  assign fire   = expire & (~mode | irq_q);
  assign irq_ce = kick | (expire & mode);
  assign irq_d  = ~kick;

  assign pcnt_ce = fire | (pcnt_q != '0);
  assign pcnt_d  = fire ? PW'(PULSE_LEN) : pcnt_q - PW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q  <= 1'b0;
      pcnt_q <= '0;
    end else begin
      if (irq_ce)  irq_q  <= irq_d;
      if (pcnt_ce) pcnt_q <= pcnt_d;
    end
  end

  assign sysrst = (pcnt_q != '0);
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
  import wdog_pkg::*;
#(
  parameter int unsigned ADDR_W    = 2,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned BASE_EXP  = 16,
  parameter int unsigned PULSE_LEN = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_o,
  output logic              sysrst_o
);
  localparam int unsigned CNT_W = BASE_EXP + (1 << SEL_W);

  ctrl_t            ctrl_q;
  range_t           range_q;
  logic             start, kick, expire;
  logic [CNT_W-1:0] cnt_q;
  logic             run_en;

  assign run_en = ctrl_q.en;

  wdog_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .cnt(cnt_q),
    .ctrl_q(ctrl_q), .range_q(range_q), .start(start), .kick(kick),
    .bus_rdata(bus_rdata)
  );

  wdog_count #(.BASE_EXP(BASE_EXP), .CNT_W(CNT_W)) u_count (
    .clk(clk), .rst_n(rst_n), .en(run_en), .start(start), .kick(kick),
    .sel_init(range_q.sel_init), .sel_run(range_q.sel_run),
    .cnt_q(cnt_q), .expire(expire)
  );

  wdog_resp #(.PULSE_LEN(PULSE_LEN)) u_resp (
    .clk(clk), .rst_n(rst_n), .expire(expire), .mode(ctrl_q.mode),
    .kick(kick), .irq_q(irq_o), .sysrst(sysrst_o)
  );
endmodule

// File: rtl/wdog_chk.sv
module wdog_chk
  import wdog_pkg::*;
#(
  parameter int unsigned ADDR_W    = 2,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned CNT_W     = 32,
  parameter int unsigned PULSE_LEN = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              en,
  input logic [CNT_W-1:0]  cnt,
  input logic              irq,
  input logic              sysrst
);
  logic        kick_wr, good_key;
  logic [31:0] hi_q;

  assign kick_wr  = bus_sel & bus_we & (bus_addr == ADDR_W'(IDX_KICK));
  assign good_key = kick_wr & (bus_wdata == DATA_W'(KICK_KEY));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      hi_q <= '0;
    else if (sysrst) hi_q <= hi_q + 32'd1;
    else             hi_q <= '0;
  end

  assert_en_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> en);

  assert_idle_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (cnt == '0) && !irq);

  assert_countdown_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (en && (cnt != '0) && !good_key) |=> (cnt == $past(cnt) - CNT_W'(1)));

  assert_badkey_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (en && (cnt != '0) && kick_wr && !good_key) |=> (cnt == $past(cnt) - CNT_W'(1)));

  assert_kick_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (en && good_key) |=> !irq);

  assert_irq_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(cnt) == '0) && $past(en));

  assert_sysrst_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sysrst) |-> ($past(cnt) == '0) && $past(en));

  assert_pulse_len_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sysrst) |-> (hi_q == 32'(PULSE_LEN)));
endmodule

bind wdog_timer wdog_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .PULSE_LEN(PULSE_LEN)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .en(run_en),
  .cnt(cnt_q), .irq(irq_o), .sysrst(sysrst_o)
);

// File: tb/wdog_timer_tb.sv
`timescale 1ns/1ps
module wdog_timer_tb;
  localparam int unsigned BASE = 4;
  localparam logic [1:0] A_CTRL = 2'd0, A_RANGE = 2'd1, A_CNT = 2'd2, A_KICK = 2'd3;

  // {running select, expected reload}
  localparam logic [35:0] VEC [5] = '{
    {4'd0,  32'd16},
    {4'd3,  32'd128},
    {4'd7,  32'd2048},
    {4'd11, 32'd32768},
    {4'd15, 32'd524288}
  };

  logic        clk, rst_n, bus_sel, bus_we, irq_o, sysrst_o;
  logic [1:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  int total = 0, bad = 0;

  wdog_timer #(.BASE_EXP(BASE), .PULSE_LEN(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_o(irq_o), .sysrst_o(sysrst_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    bus_addr = a;
    #0.5;
    d = bus_rdata;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; bus_sel = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] v, c0;
    int hi;
    do_reset();

    // R1 reset state
    rd(A_CTRL, v);  chk("R1 ctrl", v, 32'h0);
    rd(A_RANGE, v); chk("R1 range", v, 32'h0);
    rd(A_CNT, v);   chk("R1 count", v, 32'h0);
    chk("R1 irq", {31'h0, irq_o}, 32'h0);
    chk("R1 sysrst", {31'h0, sysrst_o}, 32'h0);

    // R2 readback and field masking
    wr(A_RANGE, 32'h0000_00A5); rd(A_RANGE, v); chk("R2 range", v, 32'hA5);
    wr(A_RANGE, 32'hFFFF_FF3C); rd(A_RANGE, v); chk("R2 range mask", v, 32'h3C);
    rd(A_KICK, v); chk("R2 restart reads 0", v, 32'h0);

    // R6 / R5 kick while disabled ignored, count idle at 0
    wr(A_KICK, 32'h76);
    repeat (4) @(negedge clk);
    rd(A_CNT, v); chk("R6 disabled kick", v, 32'h0);
    chk("R5 idle irq", {31'h0, irq_o}, 32'h0);

    // direct mode: init select 1 (32), running select 0 (16)
    wr(A_RANGE, 32'h10);
    wr(A_CTRL, 32'h1);
    rd(A_CNT, v); chk("R4 initial load", v, 32'd32);
    repeat (32) @(negedge clk);
    rd(A_CNT, v); chk("R5 reached zero", v, 32'd0);
    chk("R8 no early reset", {31'h0, sysrst_o}, 32'h0);
    @(negedge clk);
    chk("R8 reset raised", {31'h0, sysrst_o}, 32'h1);
    chk("R8 no irq", {31'h0, irq_o}, 32'h0);
    rd(A_CNT, v); chk("R8 reload running", v, 32'd16);
    hi = 1;
    for (int i = 0; i < 7; i++) begin
      @(negedge clk);
      if (sysrst_o) hi++;
    end
    @(negedge clk);
    chk("R11 pulse length", 32'(hi), 32'd8);
    chk("R11 pulse ended", {31'h0, sysrst_o}, 32'h0);

    // R3 sticky enable
    wr(A_CTRL, 32'h0);
    rd(A_CTRL, v); chk("R3 enable sticky", v, 32'h1);

    // R12 count read-only
    rd(A_CNT, c0);
    wr(A_CNT, 32'h1234);
    rd(A_CNT, v); chk("R12 count write ignored", v, c0 - 32'd1);

    // R6 wrong keys ignored
    rd(A_CNT, c0);
    wr(A_KICK, 32'h75);
    rd(A_CNT, v); chk("R6 bad key", v, c0 - 32'd1);
    wr(A_KICK, 32'h176);
    rd(A_CNT, v); chk("R6 bad upper bits", v, c0 - 32'd2);

    // R7 period table walk
    for (int i = 0; i < 5; i++) begin
      wr(A_RANGE, {28'h0, VEC[i][35:32]});
      wr(A_KICK, 32'h76);
      rd(A_CNT, v); chk("R7 period select", v, VEC[i][31:0]);
    end

    // two-stage mode: init select 0 (16), running select 1 (32)
    do_reset();
    wr(A_RANGE, 32'h01);
    wr(A_CTRL, 32'h3);
    rd(A_CTRL, v); chk("R2 ctrl mode", v, 32'h3);
    rd(A_CNT, v);  chk("R4 initial load 0", v, 32'd16);
    repeat (17) @(negedge clk);
    chk("R9 irq set", {31'h0, irq_o}, 32'h1);
    chk("R9 no reset", {31'h0, sysrst_o}, 32'h0);
    rd(A_CNT, v); chk("R9 reload running", v, 32'd32);
    wr(A_KICK, 32'h76);
    chk("R6 kick clears irq", {31'h0, irq_o}, 32'h0);
    rd(A_CNT, v); chk("R6 kick reload", v, 32'd32);
    repeat (33) @(negedge clk);
    chk("R9 first expiry again", {31'h0, irq_o}, 32'h1);
    chk("R9 still no reset", {31'h0, sysrst_o}, 32'h0);
    repeat (32) @(negedge clk);
    chk("R10 not yet", {31'h0, sysrst_o}, 32'h0);
    @(negedge clk);
    chk("R10 second expiry reset", {31'h0, sysrst_o}, 32'h1);
    chk("R10 irq kept", {31'h0, irq_o}, 32'h1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule